// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block couples an A-side and a B-side data bus through a set of channels, by default two channels of 8 bits each, and every channel has its own six controls. Inside each channel, one register keeps a copy of the A side and a second register keeps a copy of the B side. Each transfer direction forwards either the live value from the opposite bus or that side's stored copy, chosen by a per-direction select. A per-direction enable decides whether the receiving side is driven or left floating. Each pin group is modelled as an input vector, an output vector and an enable vector, so no tri-state nets are needed.

The capture strobes are ordinary inputs, sampled on the system clock. A register loads when its strobe was low at the previous clock edge and is high at the current one. Loading ignores the selects and the enables. A register always samples the effective value of its own bus. That value is what the block itself drives when that side is enabled, and otherwise it is the external input. As a result, a live pass-through followed by a strobe on the driven side puts one value into both registers.

Top module: `bxcvr_top`

## Requirements
- R1: Channel c uses only control bit c of each control vector and only data and enable bits [8c+7:8c]. Changing the controls or data of one channel never alters another channel's outputs or registers.
- R2: A strobe event is a strobe input that was low at the previous clock edge and is high at the current edge. On an event of cap_ab[c], the A register of channel c loads the effective A-bus value. On an event of cap_ba[c], the B register loads the effective B-bus value. The new contents are visible from that edge on.
- R3: The select and enable inputs have no effect on whether a register loads. Without a strobe event, both registers keep their values, whatever the levels on the strobe, select and enable inputs.
- R4: b_out equals a_in when sel_ab is 0 and the A register when sel_ab is 1. a_out equals b_in when sel_ba is 0 and the B register when sel_ba is 1.
- R5: All 8 b_oe bits of a channel equal oe_ab (active high). All 8 a_oe bits of a channel equal the inverse of oe_ba_n (active low).
- R6: With oe_ab=0 and oe_ba_n=1, neither side is driven. Both registers still load from the external inputs a_in and b_in.
- R7: With oe_ab=1, oe_ba_n=0 and both selects at 1, both sides are driven at once: stored A data on b_out and stored B data on a_out.
- R8: The effective bus value of a side is its own output when that side is enabled, and otherwise its external input. When B is driven live from A (oe_ab=1, sel_ab=0), a strobe event on cap_ba loads a_in into the B register. The mirror case (oe_ba_n=0, sel_ba=0) loads b_in into the A register on a cap_ab event.
- R9: The outputs follow select, register and input changes in the same cycle without a register stage. While the select and both of its sources are unchanged, the output is unchanged.
- R10: A synchronous active-low reset clears both registers of every channel and the strobe history, so a strobe that is high at reset release counts as an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 16 | External value on the A pins |
| b_in | input | 16 | External value on the B pins |
| oe_ab | input | 2 | Per channel, 1 drives the B side |
| oe_ba_n | input | 2 | Per channel, 0 drives the A side |
| cap_ab | input | 2 | Per channel A-register capture strobe |
| cap_ba | input | 2 | Per channel B-register capture strobe |
| sel_ab | input | 2 | Per channel, B-output source: 0 live A, 1 stored A |
| sel_ba | input | 2 | Per channel, A-output source: 0 live B, 1 stored B |
| a_out | output | 16 | Value offered to the A pins |
| a_oe | output | 16 | Per-bit drive enable for the A pins |
| b_out | output | 16 | Value offered to the B pins |
| b_oe | output | 16 | Per-bit drive enable for the B pins |

## Verification
On every cycle, the embedded properties check the following: register loading on strobe events and holding otherwise, reset clearing, the source choice of each output path, the absence of output change while the select and its sources are still, enable replication and isolation, and loopback loading. Only the bench's scenarios can show that channels stay independent under mixed control patterns. The same holds for the exact values carried through a loopback and read back via the stored path, and for agreement with a behavioural model across thousands of random control and data combinations.

// File: rtl/bxcvr_pkg.sv
// Package bxcvr_pkg
// Shared control bundle for one transceiver channel.
// Assumes: all controls are level signals sampled on the system clock.
package bxcvr_pkg;
    typedef struct packed {
        logic oe_ab;     // 1: drive the B side
        logic oe_ba_n;   // 0: drive the A side
        logic cap_ab;    // A-register strobe
        logic cap_ba;    // B-register strobe
        logic sel_ab;    // B output source: 0 live, 1 stored
        logic sel_ba;    // A output source: 0 live, 1 stored
    } chan_ctrl_t;
endpackage

// File: rtl/bxcvr_capture.sv
// Module bxcvr_capture
// Holds one bus copy. It loads d when the strobe rises between two clock samples.
// Assumes: strobe is synchronous to clk; rst_n is synchronous, active low.
module bxcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         fire
);
    logic hist;

    // Purpose: flag a low-to-high strobe transition at this edge.
    assign fire = strobe & ~hist;

    // Purpose: keep the strobe history and load the stored copy on an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= 1'b0;
            q    <= '0;
        end else begin
            hist <= strobe;
            if (fire) q <= d;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (q == $past(d)));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(q));
    assert_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
endmodule

// File: rtl/bxcvr_srcsel.sv
// Module bxcvr_srcsel
// Chooses live or stored data for one direction. It is combinational, in AND-OR
// form, so each bit depends on the select and its two sources only.
// Assumes: use_stored is a clean level.
module bxcvr_srcsel #(
    parameter int W = 8
) (
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    // Purpose: merge the two sources under the select.
    always_comb begin
        y = (stored & {W{use_stored}}) | (live & {W{~use_stored}});
    end
endmodule

// File: rtl/bxcvr_channel.sv
// Module bxcvr_channel
// One channel: two capture registers, two source selects, and enable fan-out.
// Each register samples its side's effective bus, which is the driven output
// when that side is enabled and the external input otherwise.
// Assumes: live paths use the external inputs, so no combinational loop forms.
module bxcvr_channel
    import bxcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  chan_ctrl_t   ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic [W-1:0] a_reg, b_reg, a_eff, b_eff;
    logic         a_drv, b_drv, a_fire, b_fire;

    // Purpose: decode the per-direction drive levels.
    assign b_drv = ctrl.oe_ab;
    assign a_drv = ~ctrl.oe_ba_n;
    assign b_oe  = {W{b_drv}};
    assign a_oe  = {W{a_drv}};

    // Purpose: form the effective value each register sees on its own bus.
    assign a_eff = a_drv ? a_out : a_in;
    assign b_eff = b_drv ? b_out : b_in;

    bxcvr_capture #(.W(W)) u_areg (
        .clk(clk), .rst_n(rst_n), .strobe(ctrl.cap_ab),
        .d(a_eff), .q(a_reg), .fire(a_fire));

    bxcvr_capture #(.W(W)) u_breg (
        .clk(clk), .rst_n(rst_n), .strobe(ctrl.cap_ba),
        .d(b_eff), .q(b_reg), .fire(b_fire));

    bxcvr_srcsel #(.W(W)) u_to_b (
        .use_stored(ctrl.sel_ab), .live(a_in), .stored(a_reg), .y(b_out));

    bxcvr_srcsel #(.W(W)) u_to_a (
        .use_stored(ctrl.sel_ba), .live(b_in), .stored(b_reg), .y(a_out));

    assert_srcsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.sel_ab ? (b_out == a_reg) : (b_out == a_in)) &&
        (ctrl.sel_ba ? (a_out == b_reg) : (a_out == b_in)));
    assert_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(ctrl.sel_ab) && $stable(a_in) && $stable(a_reg)) |-> $stable(b_out));
    assert_isolate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.oe_ab && ctrl.oe_ba_n && b_fire) |=> (b_reg == $past(b_in)));
    assert_loop_ab_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.oe_ab && !ctrl.sel_ab && b_fire) |=> (b_reg == $past(a_in)));
    assert_loop_ba_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.oe_ba_n && !ctrl.sel_ba && a_fire) |=> (a_reg == $past(b_in)));
    assert_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.oe_ab && !ctrl.oe_ba_n && ctrl.sel_ab && ctrl.sel_ba) |->
        (b_out == a_reg && a_out == b_reg && (&a_oe) && (&b_oe)));
endmodule

// File: rtl/bxcvr_top.sv
// Module bxcvr_top
// Registered bidirectional transceiver built from NCH independent channels.
// Assumes: pins are split into in/out/enable vectors; rst_n is synchronous.
module bxcvr_top
    import bxcvr_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int CH_W = 8,
    localparam int W   = NCH * CH_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic [NCH-1:0] oe_ab,
    input  logic [NCH-1:0] oe_ba_n,
    input  logic [NCH-1:0] cap_ab,
    input  logic [NCH-1:0] cap_ba,
    input  logic [NCH-1:0] sel_ab,
    input  logic [NCH-1:0] sel_ba,
    output logic [W-1:0]   a_out,
    output logic [W-1:0]   a_oe,
    output logic [W-1:0]   b_out,
    output logic [W-1:0]   b_oe
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_ctrl_t ctl;

        // Purpose: gather this channel's control bits into one bundle.
        assign ctl = '{oe_ab: oe_ab[c], oe_ba_n: oe_ba_n[c], cap_ab: cap_ab[c],
                       cap_ba: cap_ba[c], sel_ab: sel_ab[c], sel_ba: sel_ba[c]};

        bxcvr_channel #(.W(CH_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .ctrl(ctl),
            .a_in(a_in[c*CH_W +: CH_W]), .b_in(b_in[c*CH_W +: CH_W]),
            .a_out(a_out[c*CH_W +: CH_W]), .a_oe(a_oe[c*CH_W +: CH_W]),
            .b_out(b_out[c*CH_W +: CH_W]), .b_oe(b_oe[c*CH_W +: CH_W]));

        assert_oe_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
            oe_ab[c] ? (&b_oe[c*CH_W +: CH_W]) : ($countones(b_oe[c*CH_W +: CH_W]) == 0));
        assert_oe_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
            oe_ba_n[c] ? ($countones(a_oe[c*CH_W +: CH_W]) == 0) : (&a_oe[c*CH_W +: CH_W]));
        assert_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_ab[c] && oe_ba_n[c]) |->
            ($countones(a_oe[c*CH_W +: CH_W]) == 0 && $countones(b_oe[c*CH_W +: CH_W]) == 0));
    end
endmodule

// File: tb/bxcvr_top_tb_top.sv
`timescale 1ns/1ps
module bxcvr_top_tb_top;
    localparam int NCH = 2;
    localparam int CW  = 8;
    localparam int W   = NCH * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]   a_in = '0, b_in = '0;
    logic [NCH-1:0] oe_ab = '0, oe_ba_n = '1, cap_ab = '0, cap_ba = '0;
    logic [NCH-1:0] sel_ab = '0, sel_ba = '0;
    logic [W-1:0]   a_out, a_oe, b_out, b_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // Behavioural reference state
    logic [CW-1:0] ra [NCH];
    logic [CW-1:0] rb [NCH];
    bit            ha [NCH];
    bit            hb [NCH];
    logic [W-1:0]  ex_a, ex_aoe, ex_b, ex_boe;

    always #2 clk = ~clk;

    bxcvr_top #(.NCH(NCH), .CH_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

    initial begin
        for (int c = 0; c < NCH; c++) begin
            ra[c] = '0; rb[c] = '0; ha[c] = 0; hb[c] = 0;
        end
    end

    // Expected pin values from the model state and present inputs
    task automatic model_outputs();
        for (int c = 0; c < NCH; c++) begin
            ex_b[c*CW +: CW]   = sel_ab[c] ? ra[c] : a_in[c*CW +: CW];
            ex_a[c*CW +: CW]   = sel_ba[c] ? rb[c] : b_in[c*CW +: CW];
            ex_boe[c*CW +: CW] = oe_ab[c]   ? '1 : '0;
            ex_aoe[c*CW +: CW] = oe_ba_n[c] ? '0 : '1;
        end
    endtask

    // Model register update at each clock edge
    always @(posedge clk) begin
        logic [CW-1:0] ea, eb;
        cycles++;
        model_outputs();
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                ra[c] = '0; rb[c] = '0; ha[c] = 0; hb[c] = 0;
            end else begin
                ea = oe_ba_n[c] ? a_in[c*CW +: CW] : ex_a[c*CW +: CW];
                eb = oe_ab[c]   ? ex_b[c*CW +: CW] : b_in[c*CW +: CW];
                if (cap_ab[c] && !ha[c]) ra[c] = ea;
                if (cap_ba[c] && !hb[c]) rb[c] = eb;
                ha[c] = cap_ab[c];
                hb[c] = cap_ba[c];
            end
        end
    end

    // Wait for the next falling edge and compare all outputs to the model
    task automatic step(input string tag);
        @(negedge clk);
        model_outputs();
        n_tests++;
        if (a_out !== ex_a || b_out !== ex_b || a_oe !== ex_aoe || b_oe !== ex_boe) begin
            n_fail++;
            $display("FAIL %s a_out=%h/%h b_out=%h/%h a_oe=%h/%h b_oe=%h/%h (actual/expected)",
                     tag, a_out, ex_a, b_out, ex_b, a_oe, ex_aoe, b_oe, ex_boe);
        end
    endtask

    task automatic chk8(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        // R10: reset clears registers, stored path reads zero
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        @(negedge clk); @(negedge clk);
        sel_ab = '1; sel_ba = '1;
        step("R10 reset");
        chk8("R10 reset A reg ch0", b_out[7:0], 8'h00);
        chk8("R10 reset B reg ch1", a_out[15:8], 8'h00);
        rst_n = 1'b1;
        step("R10 release");

        // R4: live pass-through on both directions
        sel_ab = '0; sel_ba = '0; a_in = 16'h1234; b_in = 16'hABCD;
        step("R4 live");
        chk8("R4 live b_out ch0", b_out[7:0], 8'h34);
        chk8("R4 live a_out ch1", a_out[15:8], 8'hAB);

        // R2/R6: isolation, capture external inputs on both channels
        oe_ab = '0; oe_ba_n = '1;
        cap_ab = '1; cap_ba = '1;
        step("R6 isolate capture");
        cap_ab = '0; cap_ba = '0; sel_ab = '1; sel_ba = '1;
        a_in = 16'h0000; b_in = 16'h0000;
        step("R2 stored");
        chk8("R2 stored A ch0", b_out[7:0], 8'h34);
        chk8("R6 stored B ch1", a_out[15:8], 8'hAB);

        // R3: held strobe and toggling selects/enables do not reload
        a_in = 16'h5555; b_in = 16'h6666; cap_ab = '1;
        step("R3 new edge");
        for (int k = 0; k < 6; k++) begin
            sel_ab = k[1:0]; oe_ab = k[2:1]; oe_ba_n = ~k[1:0];
            a_in = a_in + 16'h1111;
            step("R3 held strobe");
        end
        cap_ab = '0; sel_ab = '1; oe_ab = '0; oe_ba_n = '1;
        step("R3 hold");
        chk8("R3 A reg ch0 unchanged", b_out[7:0], 8'h55);

        // R5/R7: both sides driven from stored data
        oe_ab = '1; oe_ba_n = '0; sel_ab = '1; sel_ba = '1;
        step("R7 both driven");
        chk8("R7 b_out ch1", b_out[15:8], 8'h55);
        chk8("R5 a_oe ch0", a_oe[7:0], 8'hFF);

        // R8: loopback A->B on ch0, B->A on ch1
        oe_ab = 2'b01; oe_ba_n = 2'b01; sel_ab = 2'b10; sel_ba = 2'b01;
        a_in = 16'h775A; b_in = 16'hC333;
        step("R8 setup");
        cap_ab = 2'b11; cap_ba = 2'b01;
        step("R8 loop strobe");
        cap_ab = '0; cap_ba = '0; sel_ab = '1; sel_ba = '1;
        a_in = '0; b_in = '0;
        step("R8 readback");
        chk8("R8 ch0 B reg", a_out[7:0], 8'h5A);
        chk8("R8 ch0 A reg", b_out[7:0], 8'h5A);
        chk8("R8 ch1 A reg", b_out[15:8], 8'hC3);

        // R9: select toggling with steady sources
        a_in = 16'h0F0F; b_in = 16'hF0F0;
        for (int k = 0; k < 8; k++) begin
            sel_ab = k[1:0]; sel_ba = k[2:1];
            step("R9 select toggle");
        end

        // R1: random mixed per-channel patterns
        for (int k = 0; k < 4000; k++) begin
            a_in = 16'($urandom); b_in = 16'($urandom);
            {oe_ab, oe_ba_n, cap_ab} = 6'($urandom);
            {cap_ba, sel_ab, sel_ba} = 6'($urandom);
            if (k % 97 == 5) rst_n = 1'b0; else rst_n = 1'b1;
            step("R1 random");
        end
        finish_run();
    end
endmodule